// File: doc/BRIEF.md
# Sign-Magnitude Adder/Subtractor

This block adds or subtracts two signed integers held in sign-magnitude form. Each operand is WIDTH bits wide. The top bit is the sign and the remaining WIDTH-1 bits are an unsigned absolute value. The signs and magnitudes are not in two's complement, so the block cannot simply add the raw bits. It first settles the effective sign of each operand. It then either sums the two magnitudes, or takes the larger magnitude minus the smaller one.

A subtract request is handled by flipping the sign of the second operand before the add rules are applied. The block produces:
- the result in the same format;
- an overflow flag, raised when the magnitude field cannot hold the result;
- a flag that marks an exact zero result.

A zero result is always given as positive zero. Both encodings of zero are accepted as inputs. With REGISTERED set, the result is captured in output registers one clock after the operands are presented. With REGISTERED cleared, the block is purely combinational.

Top module: `smag_addsub`

## Requirements
- R1: Operand and result encoding: bit WIDTH-1 is the sign (1 = negative) and bits WIDTH-2..0 hold the magnitude, so in 4 bits the pattern 1011 is -3.
- R2: When the effective signs are equal, the result magnitude is the sum of the operand magnitudes and the result carries that shared sign.
- R3: When the effective signs differ, the result magnitude is the larger magnitude minus the smaller one, and the result takes the sign of the operand with the larger magnitude.
- R4: With sub_i = 1 the result is op_a minus op_b, obtained by inverting the sign bit of op_b and then applying R2/R3.
- R5: Differing effective signs with equal magnitudes give +0 (all bits clear) with zero_o = 1.
- R6: Both +0 and -0 are accepted as zero inputs, and every exact zero result, including -0 plus -0, is output as +0 with zero_o = 1. Any nonzero result has zero_o = 0.
- R7: A same-sign addition whose magnitude sum exceeds 2^(WIDTH-1)-1 sets ovf_o = 1. The output magnitude is the sum modulo 2^(WIDTH-1), the shared sign is kept, and zero_o = 0.
- R8: ovf_o is never set when the effective signs differ.
- R9: With REGISTERED = 1 the outputs reflect the operands present at the previous rising clock edge. With REGISTERED = 0 they follow the operands combinationally.
- R10: While reset is held, and until the internal reset is released, the registered outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_a | input | WIDTH | First operand, sign-magnitude |
| op_b | input | WIDTH | Second operand, sign-magnitude |
| sub_i | input | 1 | 1 = subtract op_b from op_a, 0 = add |
| res_o | output | WIDTH | Result, sign-magnitude, zero always positive |
| ovf_o | output | 1 | Magnitude overflow on same-sign addition |
| zero_o | output | 1 | Result is exactly zero |

## Verification
Several properties are checked on every cycle:
- a raised zero flag always comes with an all-clear result;
- no negative zero ever leaves the block unless overflow is set;
- overflow and zero are never raised together;
- a cycle with differing effective signs is never followed by overflow;
- an overflowed result keeps the first operand's sign.

The arithmetic itself can only be shown by the bench, which runs every operand pair in both modes at 5 bits against an integer model. That covers the choice of the larger magnitude, subtraction by sign flip, the wrapped magnitude on overflow, and zero normalisation.

// File: rtl/smag_pkg.sv
package smag_pkg;
  // Which magnitude result feeds the output
  typedef enum logic [1:0] {
    PATH_SUM  = 2'd0,  // same effective sign: |a| + |b|
    PATH_AMB  = 2'd1,  // |a| >= |b|, signs differ: |a| - |b|
    PATH_BMA  = 2'd2   // |b| >  |a|, signs differ: |b| - |a|
  } smag_path_e;
endpackage

// File: rtl/smag_fa.sv
module smag_fa (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (a & ci) | (b & ci);
endmodule

// File: rtl/smag_ripple.sv
module smag_ripple #(
  parameter int N = 7
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         ci,
  output logic [N-1:0] s,
  output logic         co
);
  logic [N:0] carry;
  assign carry[0] = ci;

  for (genvar i = 0; i < N; i++) begin : g_stage
    smag_fa u_fa (
      .a  (a[i]),
      .b  (b[i]),
      .ci (carry[i]),
      .s  (s[i]),
      .co (carry[i+1])
    );
  end

  assign co = carry[N];
endmodule

// File: rtl/smag_core.sv
module smag_core
  import smag_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] res,
  output logic             ovf,
  output logic             zero
);
  localparam int M = WIDTH - 1;

  logic         sgn_a, sgn_b;
  logic [M-1:0] mag_a, mag_b;
  logic [M-1:0] sum_m, amb_m, bma_m;
  logic         sum_c, a_ge_b, bma_c;
  logic [M-1:0] mag_sel;
  logic         sgn_sel;
  smag_path_e   path;

  assign sgn_a = a[WIDTH-1];
  assign sgn_b = b[WIDTH-1] ^ sub;   // subtract = flip sign of b
  assign mag_a = a[M-1:0];
  assign mag_b = b[M-1:0];

  // |a| + |b|
  smag_ripple #(.N(M)) u_sum (
    .a (mag_a), .b (mag_b), .ci (1'b0), .s (sum_m), .co (sum_c)
  );
  // |a| - |b|; carry out set when |a| >= |b|
  smag_ripple #(.N(M)) u_amb (
    .a (mag_a), .b (~mag_b), .ci (1'b1), .s (amb_m), .co (a_ge_b)
  );
  // |b| - |a|
  smag_ripple #(.N(M)) u_bma (
    .a (mag_b), .b (~mag_a), .ci (1'b1), .s (bma_m), .co (bma_c)
  );

  always_comb begin
    if (sgn_a == sgn_b)  path = PATH_SUM;
    else if (a_ge_b)     path = PATH_AMB;
    else                 path = PATH_BMA;
  end

  always_comb begin
    unique case (path)
      PATH_SUM: begin mag_sel = sum_m; sgn_sel = sgn_a; end
      PATH_AMB: begin mag_sel = amb_m; sgn_sel = sgn_a; end
      default:  begin mag_sel = bma_m; sgn_sel = sgn_b; end
    endcase
  end

  logic unused_c;
  assign unused_c = bma_c;

  assign ovf  = (path == PATH_SUM) & sum_c;
  assign zero = ~ovf & (mag_sel == '0);
  assign res  = {sgn_sel & ~zero, mag_sel};
endmodule

// File: rtl/smag_addsub.sv
module smag_addsub #(
  parameter int WIDTH      = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_i,
  output logic [WIDTH-1:0] res_o,
  output logic             ovf_o,
  output logic             zero_o
);
  logic [WIDTH-1:0] res_d;
  logic             ovf_d, zero_d;

  smag_core #(.WIDTH(WIDTH)) u_core (
    .a    (op_a),
    .b    (op_b),
    .sub  (sub_i),
    .res  (res_d),
    .ovf  (ovf_d),
    .zero (zero_d)
  );

  if (REGISTERED) begin : g_reg
    logic [1:0]       rst_sync_q;
    logic             rst_int_n;
    logic             cap_en;
    logic [WIDTH-1:0] res_q;
    logic             ovf_q, zero_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_sync_q <= 2'b00;
      else        rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
    assign rst_int_n = rst_sync_q[1];
    assign cap_en    = 1'b1;

    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) begin
        res_q  <= '0;
        ovf_q  <= 1'b0;
        zero_q <= 1'b0;
      end else if (cap_en) begin
        res_q  <= res_d;
        ovf_q  <= ovf_d;
        zero_q <= zero_d;
      end
    end

    assign res_o  = res_q;
    assign ovf_o  = ovf_q;
    assign zero_o = zero_q;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign res_o  = res_d;
    assign ovf_o  = ovf_d;
    assign zero_o = zero_d;
  end
endmodule

// File: rtl/smag_addsub_chk.sv
module smag_addsub_chk #(
  parameter int WIDTH      = 8,
  parameter bit REGISTERED = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             sub_i,
  input logic [WIDTH-1:0] res_o,
  input logic             ovf_o,
  input logic             zero_o
);
  // R6
  zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |-> (res_o == '0));
  // R6
  no_neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_o && res_o[WIDTH-2:0] == '0) |-> !res_o[WIDTH-1]);
  // R7
  ovf_not_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> !zero_o);

  if (REGISTERED) begin : g_seq
    // R8
    diff_sign_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_a[WIDTH-1] != (op_b[WIDTH-1] ^ sub_i)) |=> !ovf_o);
    // R7
    ovf_keeps_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> (res_o[WIDTH-1] == $past(op_a[WIDTH-1])));
  end else begin : g_cmb
    // R8
    diff_sign_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_a[WIDTH-1] != (op_b[WIDTH-1] ^ sub_i)) |-> !ovf_o);
  end
endmodule

bind smag_addsub smag_addsub_chk #(.WIDTH(WIDTH), .REGISTERED(REGISTERED)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .op_a   (op_a),
  .op_b   (op_b),
  .sub_i  (sub_i),
  .res_o  (res_o),
  .ovf_o  (ovf_o),
  .zero_o (zero_o)
);

// File: tb/tb_smag_addsub.sv
`timescale 1ns/1ps
module tb_smag_addsub;
  localparam int W    = 5;
  localparam int M    = W - 1;
  localparam int MAXM = (1 << M) - 1;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] op_a, op_b;
  logic         sub_i;
  logic [W-1:0] res_o;
  logic         ovf_o, zero_o;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [W-1:0] res;
    logic         ovf;
    logic         zero;
    string        tag;
  } exp_t;
  exp_t expq[$];

  smag_addsub #(.WIDTH(W), .REGISTERED(1'b1)) dut (
    .clk (clk), .rst_n (rst_n), .op_a (op_a), .op_b (op_b), .sub_i (sub_i),
    .res_o (res_o), .ovf_o (ovf_o), .zero_o (zero_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  // R1: sign bit on top, magnitude below
  function automatic int to_int(logic [W-1:0] v);
    int m;
    m = int'(v[M-1:0]);
    return v[W-1] ? -m : m;
  endfunction

  function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b, logic s);
    exp_t e;
    int va, vb, r, ar;
    logic sa, sb;
    sa = a[W-1];
    sb = b[W-1] ^ s;
    va = to_int(a);
    vb = to_int(b);
    if (s) vb = -vb;
    r  = va + vb;
    ar = (r < 0) ? -r : r;
    if (ar > MAXM) begin
      e.ovf = 1'b1; e.zero = 1'b0;
      e.res = {sa, M'(ar - (MAXM + 1))};
      e.tag = "R7";
    end else if (r == 0) begin
      e.ovf = 1'b0; e.zero = 1'b1; e.res = '0;
      e.tag = (sa != sb) ? "R5" : "R6";
    end else begin
      e.ovf = 1'b0; e.zero = 1'b0;
      e.res = {(r < 0) ? 1'b1 : 1'b0, M'(ar)};
      e.tag = s ? "R4" : ((sa == sb) ? "R2" : "R3");
    end
    return e;
  endfunction

  task automatic check(string tag, logic [W-1:0] er, logic eo, logic ez);
    checks++;
    if (res_o !== er || ovf_o !== eo || zero_o !== ez) begin
      fails++;
      $display("FAIL %s: got res=%b ovf=%b zero=%b, expected res=%b ovf=%b zero=%b",
               tag, res_o, ovf_o, zero_o, er, eo, ez);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    exp_t e;
    rst_n = 1'b0;
    op_a  = '0; op_b = '0; sub_i = 1'b0;
    repeat (3) @(negedge clk);
    // R10: outputs clear while reset is held, even with live operands
    op_a = 5'b00111; op_b = 5'b00010;
    @(negedge clk);
    check("R10", '0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", '0, 1'b0, 1'b0);   // internal reset still held
    repeat (3) @(negedge clk);

    // R9: each vector is checked one clock after it is driven
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) begin
          op_a  = W'(a);
          op_b  = W'(b);
          sub_i = s[0];
          expq.push_back(model(W'(a), W'(b), s[0]));
          @(negedge clk);
          e = expq.pop_front();
          check({e.tag, "/R9"}, e.res, e.ovf, e.zero);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule